// File: doc/BRIEF.md
# Configurable CRC-32/CRC-16 Engine

A register-mapped checksum accelerator that folds every store into a running CRC within the clock cycle it arrives, so software or a copy loop can stream data at full bus rate. The size of each store, given by its byte strobes, sets how many bits enter the generator. A byte feeds 8 bits, a half-word 16 and a word 32.

A control register picks the generator width and the processing options. The options are the order in which input bytes are consumed, bit reflection of each byte and of the result, and byte swapping of the result. The byte swap depends on the read size. A seed register presets the running value. A 512-word window of aliases all lead to the input path, so a plain block copy can feed the engine. No final XOR is applied; software adds it if a standard checksum needs it.

Top module: `crc_engine`

## Requirements
- R1: After reset the control register reads 0 and the result register reads 0.
- R2: The control register sits at offset 0x1100 and is written when strobe bit 0 is set. Bit 0 selects 16-bit mode, bit 1 enables reflection, bit 2 selects highest-lane-first input and bit 4 enables output swap. It reads back those four bits, and every other bit reads 0.
- R3: A full-word write to the seed offset 0x1104 loads the running CRC in that cycle, and a read in the next cycle returns it. In 16-bit mode only seed bits 15:0 are kept.
- R4: In 32-bit mode each input byte is folded MSB-first through polynomial 0x04C11DB7. The legal strobe patterns are 0001, 0010, 0100, 1000 (one byte), 0011, 1100 (half-word) and 1111 (word). Any other strobe pattern on an input write leaves the CRC unchanged.
- R5: In 16-bit mode each input byte is folded MSB-first through polynomial 0x1021 into a 16-bit CRC.
- R6: With control bit 2 clear, the enabled lanes are consumed lowest lane first. With it set, they are consumed highest lane first.
- R7: With control bit 1 set, each input byte is bit-reversed before folding. The result reads bit-reversed over 32 bits in 32-bit mode and over 16 bits in 16-bit mode.
- R8: The read size is coded as 0 for byte, 1 for half-word and 2 or 3 for word. A byte read returns result bits 7:0. With control bit 4 set, a half-word read returns the low two result bytes swapped, and a 32-bit-mode word read returns all four bytes reversed.
- R9: In 16-bit mode a word read has bits 31:16 at 0. With control bit 4 set, the two low bytes are swapped.
- R10: Every word offset 0x1800 + 4*y, for y from 0 to 511, acts as the input register at 0x1108.
- R11: Writes to any other offset change nothing. Reads of the seed, input, alias and unmapped offsets return 0, as does any cycle without a read.
- R12: Back-to-back input writes on consecutive cycles are each folded with no stall, and the result is readable in the cycle after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write access this cycle |
| rd_en_i | input | 1 | Read access this cycle |
| word_addr_i | input | ADDR_W-2 | Register offset divided by 4 |
| wr_strb_i | input | 4 | Byte strobes, which give the write size and lanes |
| wr_data_i | input | 32 | Write data |
| rd_size_i | input | 2 | Read size: 0 byte, 1 half-word, 2 or 3 word |
| rd_data_o | output | 32 | Read data, valid in the same cycle |

## Verification
The engine is run on the ASCII string "123456789" with known check values. Reflected 32-bit mode with an all-ones seed gives 0x340BC6D9. 16-bit mode gives 0x29B1 with an all-ones seed and 0x31C3 with a zero seed. These values separate the two polynomials and the reflection paths. Words, half-words in the upper lanes, single bytes and illegal strobes are each fed with both input orders. A model in the bench shows whether lane selection and ordering differ, and a swapped order gives a different CRC. Asymmetric seeds read at every size, with and without swap and reflection, reveal any wrong byte or bit position in the output formatting.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned CNT_W  = $clog2(LANES + 1);

  typedef struct packed {
    logic out_swap;
    logic in_hi_first;
    logic bit_rev;
    logic poly16;
  } crc_ctrl_t;

  function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  // Bit-serial LFSR form, MSB of the byte first
  function automatic logic [WORD_W-1:0] fold_byte(input logic [WORD_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic narrow,
                                                  input logic [31:0] p32,
                                                  input logic [15:0] p16);
    logic [WORD_W-1:0] s;
    logic fb;
    s = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (narrow) begin
        fb = s[15] ^ b[i];
        s  = {16'h0, s[14:0], 1'b0} ^ (fb ? {16'h0, p16} : 32'h0);
      end else begin
        fb = s[31] ^ b[i];
        s  = {s[30:0], 1'b0} ^ (fb ? p32 : 32'h0);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/crc_lane_sel.sv
module crc_lane_sel
  import crc_pkg::*;
(
  input  logic [LANES-1:0]             strb_i,
  input  logic [WORD_W-1:0]            data_i,
  input  logic                         hi_first_i,
  input  logic                         bit_rev_i,
  output logic [LANES-1:0][BYTE_W-1:0] bytes_o,
  output logic [CNT_W-1:0]             count_o,
  output logic                         legal_o
);
  logic [1:0] base;

  always_comb begin
    legal_o = 1'b1;
    base    = 2'd0;
    count_o = CNT_W'(1);
    unique case (strb_i)
      4'b0001: base = 2'd0;
      4'b0010: base = 2'd1;
      4'b0100: base = 2'd2;
      4'b1000: base = 2'd3;
      4'b0011: begin base = 2'd0; count_o = CNT_W'(2); end
      4'b1100: begin base = 2'd2; count_o = CNT_W'(2); end
      4'b1111: begin base = 2'd0; count_o = CNT_W'(4); end
      default: begin legal_o = 1'b0; count_o = '0; end
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_ord
    logic [1:0]        sel;
    logic [BYTE_W-1:0] raw;
    always_comb begin
      if (hi_first_i) sel = 2'(int'(base) + int'(count_o) - 1 - k);
      else            sel = 2'(int'(base) + k);
      raw        = data_i[BYTE_W*sel +: BYTE_W];
      bytes_o[k] = bit_rev_i ? rev8(raw) : raw;
    end
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_pkg::*;
#(
  parameter logic [31:0] POLY32 = 32'h04C1_1DB7,
  parameter logic [15:0] POLY16 = 16'h1021
) (
  input  logic [WORD_W-1:0]            state_i,
  input  logic [LANES-1:0][BYTE_W-1:0] bytes_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic                         narrow_i,
  output logic [WORD_W-1:0]            next_o
);
  logic [LANES:0][WORD_W-1:0] stage;

  assign stage[0] = state_i;
  for (genvar k = 0; k < LANES; k++) begin : g_stage
    assign stage[k+1] = (count_i > CNT_W'(k))
                        ? fold_byte(stage[k], bytes_i[k], narrow_i, POLY32, POLY16)
                        : stage[k];
  end
  assign next_o = stage[LANES];
endmodule

// File: rtl/crc_rd_fmt.sv
module crc_rd_fmt
  import crc_pkg::*;
(
  input  logic [WORD_W-1:0] crc_i,
  input  crc_ctrl_t         ctrl_i,
  input  logic [1:0]        size_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] rv32, r;
  logic [15:0]       rv16;

  always_comb begin
    for (int i = 0; i < 32; i++) rv32[i] = crc_i[31-i];
    for (int i = 0; i < 16; i++) rv16[i] = crc_i[15-i];
    if (ctrl_i.poly16) r = {16'h0, ctrl_i.bit_rev ? rv16 : crc_i[15:0]};
    else               r = ctrl_i.bit_rev ? rv32 : crc_i;
    unique case (size_i)
      2'd0: data_o = {24'h0, r[7:0]};
      2'd1: data_o = ctrl_i.out_swap ? {16'h0, r[7:0], r[15:8]} : {16'h0, r[15:0]};
      default: begin
        if (!ctrl_i.out_swap)   data_o = r;
        else if (ctrl_i.poly16) data_o = {16'h0, r[7:0], r[15:8]};
        else                    data_o = {r[7:0], r[15:8], r[23:16], r[31:24]};
      end
    endcase
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 13,
  parameter logic [ADDR_W-1:0]  CTRL_OFF    = 13'h1100,
  parameter logic [ADDR_W-1:0]  SEED_OFF    = 13'h1104,
  parameter logic [ADDR_W-1:0]  IN_OFF      = 13'h1108,
  parameter logic [ADDR_W-1:0]  OUT_OFF     = 13'h110C,
  parameter logic [ADDR_W-1:0]  ALIAS_BASE  = 13'h1800,
  parameter int unsigned        ALIAS_WORDS = 512,
  parameter logic [31:0]        POLY32      = 32'h04C1_1DB7,
  parameter logic [15:0]        POLY16      = 16'h1021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-3:0] word_addr_i,
  input  logic [3:0]        wr_strb_i,
  input  logic [31:0]       wr_data_i,
  input  logic [1:0]        rd_size_i,
  output logic [31:0]       rd_data_o
);
  localparam logic [ADDR_W-3:0] CTRL_W   = CTRL_OFF[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] SEED_W   = SEED_OFF[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] IN_W     = IN_OFF[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] OUT_W    = OUT_OFF[ADDR_W-1:2];
  localparam int unsigned       ALIAS_LO = int'(ALIAS_BASE[ADDR_W-1:2]);
  localparam int unsigned       ALIAS_HI = ALIAS_LO + ALIAS_WORDS;

  crc_ctrl_t         ctrl_q;
  logic [WORD_W-1:0] crc_q, fold_next, seed_val, fmt_data;
  logic              ctrl_hit, seed_hit, out_hit, alias_hit, in_hit, legal;
  logic [LANES-1:0][BYTE_W-1:0] ord_bytes;
  logic [CNT_W-1:0]  nbytes;

  always_comb begin
    ctrl_hit  = word_addr_i == CTRL_W;
    seed_hit  = word_addr_i == SEED_W;
    out_hit   = word_addr_i == OUT_W;
    alias_hit = (int'(word_addr_i) >= ALIAS_LO) && (int'(word_addr_i) < ALIAS_HI);
    in_hit    = (word_addr_i == IN_W) || alias_hit;
  end

  crc_lane_sel u_lane_sel (
    .strb_i    (wr_strb_i),
    .data_i    (wr_data_i),
    .hi_first_i(ctrl_q.in_hi_first),
    .bit_rev_i (ctrl_q.bit_rev),
    .bytes_o   (ord_bytes),
    .count_o   (nbytes),
    .legal_o   (legal)
  );

  crc_fold #(.POLY32(POLY32), .POLY16(POLY16)) u_fold (
    .state_i (crc_q),
    .bytes_i (ord_bytes),
    .count_i (nbytes),
    .narrow_i(ctrl_q.poly16),
    .next_o  (fold_next)
  );

  crc_rd_fmt u_rd_fmt (
    .crc_i (crc_q),
    .ctrl_i(ctrl_q),
    .size_i(rd_size_i),
    .data_o(fmt_data)
  );

  // Seed merges per strobed lane; 16-bit mode keeps the low half only
  always_comb begin
    for (int l = 0; l < LANES; l++)
      seed_val[BYTE_W*l +: BYTE_W] = wr_strb_i[l] ? wr_data_i[BYTE_W*l +: BYTE_W]
                                                  : crc_q[BYTE_W*l +: BYTE_W];
    if (ctrl_q.poly16) seed_val[31:16] = 16'h0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      crc_q  <= '0;
    end else if (wr_en_i) begin
      if (ctrl_hit && wr_strb_i[0])
        ctrl_q <= '{out_swap: wr_data_i[4], in_hi_first: wr_data_i[2],
                    bit_rev: wr_data_i[1], poly16: wr_data_i[0]};
      if (seed_hit)             crc_q <= seed_val;
      else if (in_hit && legal) crc_q <= fold_next;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (out_hit)       rd_data_o = fmt_data;
      else if (ctrl_hit) rd_data_o = {27'h0, ctrl_q.out_swap, 1'b0, ctrl_q.in_hi_first,
                                      ctrl_q.bit_rev, ctrl_q.poly16};
    end
  end

  a_r3_seed_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && seed_hit && wr_strb_i == 4'hF) |=>
      crc_q == ($past(ctrl_q.poly16) ? {16'h0, $past(wr_data_i[15:0])} : $past(wr_data_i)));

  a_r4_illegal_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_hit && !legal) |=> $stable(crc_q));

  a_r4_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |-> int'(nbytes) == $countones(wr_strb_i));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ctrl_q.poly16) |-> rd_data_o[31:16] == 16'h0);

  a_r11_reserved_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ctrl_hit && !seed_hit && !in_hit) |=> ($stable(crc_q) && $stable(ctrl_q)));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(crc_q));
endmodule

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
  localparam time TCK = 20ns;
  localparam logic [12:0] A_CTRL = 13'h1100, A_SEED = 13'h1104, A_IN = 13'h1108,
                          A_OUT = 13'h110C;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [10:0] waddr = '0;
  logic [3:0]  strb = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  rsize = '0;
  logic [31:0] rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [4:0]  m_ctrl = '0;
  logic [31:0] m_crc = '0;

  always #(TCK/2) clk = ~clk;

  crc_engine u_crc_engine (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .word_addr_i(waddr), .wr_strb_i(strb), .wr_data_i(wdata),
    .rd_size_i(rsize), .rd_data_o(rdata)
  );

  function automatic logic [31:0] m_fold(logic [31:0] c, logic [7:0] b, logic narrow);
    if (narrow) begin
      logic [15:0] h = c[15:0] ^ {b, 8'h0};
      repeat (8) h = h[15] ? ((h << 1) ^ 16'h1021) : (h << 1);
      return {16'h0, h};
    end
    c = c ^ {b, 24'h0};
    repeat (8) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    return c;
  endfunction

  function automatic logic [31:0] m_read(logic [12:0] a, logic [1:0] sz);
    logic [31:0] r;
    if (a[12:2] == A_CTRL[12:2]) return {27'h0, m_ctrl};
    if (a[12:2] != A_OUT[12:2]) return 32'h0;
    r = m_ctrl[0] ? {16'h0, m_crc[15:0]} : m_crc;
    if (m_ctrl[1]) r = m_ctrl[0] ? {16'h0, {<<{m_crc[15:0]}}} : {<<{m_crc}};
    if (sz == SZ_B) return {24'h0, r[7:0]};
    if (sz == SZ_H) return m_ctrl[4] ? {16'h0, r[7:0], r[15:8]} : {16'h0, r[15:0]};
    if (!m_ctrl[4]) return r;
    if (m_ctrl[0]) return {16'h0, r[7:0], r[15:8]};
    return {<<8{r}};
  endfunction

  task automatic m_write(logic [12:0] a, logic [3:0] s, logic [31:0] d);
    logic [7:0] q[$];
    if (a[12:2] == A_CTRL[12:2] && s[0]) m_ctrl = d[4:0] & 5'b10111;
    else if (a[12:2] == A_SEED[12:2]) m_crc = m_ctrl[0] ? {16'h0, d[15:0]} : d;
    else if (a[12:2] == A_IN[12:2] || a >= 13'h1800) begin
      if (!(s inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111})) return;
      for (int l = 0; l < 4; l++) if (s[l]) q.push_back(d[8*l +: 8]);
      if (m_ctrl[2]) q.reverse();
      foreach (q[i]) m_crc = m_fold(m_crc, m_ctrl[1] ? {<<{q[i]}} : q[i], m_ctrl[0]);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [3:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; waddr = a[12:2]; strb = s; wdata = d;
    m_write(a, s, d);
  endtask

  task automatic rdx(logic [12:0] a, logic [1:0] sz, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    wr_en = 1'b0; rd_en = 1'b1; waddr = a[12:2]; rsize = sz;
  endtask

  task automatic rd(logic [12:0] a, logic [1:0] sz, string tag);
    rdx(a, sz, m_read(a, sz), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Monitor: sample a quarter period after the driving edge, before the state edge
  initial forever begin
    @(negedge clk);
    #(TCK/4);
    if (rd_en) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %08h expected %08h", t, rdata, e);
      end
    end
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rdx(A_CTRL, SZ_W, 32'h0, "R1 control after reset");
    rdx(A_OUT, SZ_W, 32'h0, "R1 result after reset");

    wr(A_CTRL, 4'hF, 32'hFFFF_FFFF);
    rdx(A_CTRL, SZ_W, 32'h17, "R2 control readback");
    wr(A_CTRL, 4'b0010, 32'h0);
    rdx(A_CTRL, SZ_W, 32'h17, "R2 write without strobe 0 ignored");
    wr(A_CTRL, 4'h1, 32'h0);
    rd(A_CTRL, SZ_W, "R2 control cleared");

    // R4 R7: reflected check string, seed all ones, no final XOR
    wr(A_CTRL, 4'h1, 32'h2);
    wr(A_SEED, 4'hF, 32'hFFFF_FFFF);
    wr(A_IN, 4'hF, 32'h3433_3231);
    wr(A_IN, 4'hF, 32'h3837_3635);
    wr(A_IN, 4'h1, 32'h0000_0039);
    rdx(A_OUT, SZ_W, 32'h340B_C6D9, "R4 R7 R12 reflected 32-bit check value");

    // R5: 16-bit check values
    wr(A_CTRL, 4'h1, 32'h1);
    wr(A_SEED, 4'hF, 32'hFFFF_FFFF);
    wr(A_IN, 4'hF, 32'h3433_3231);
    wr(A_IN, 4'hF, 32'h3837_3635);
    wr(A_IN, 4'h1, 32'h0000_0039);
    rdx(A_OUT, SZ_W, 32'h0000_29B1, "R5 16-bit check value, seed FFFF");
    wr(A_SEED, 4'hF, 32'h0);
    wr(A_IN, 4'hF, 32'h3433_3231);
    wr(A_IN, 4'hF, 32'h3837_3635);
    wr(A_IN, 4'h1, 32'h0000_0039);
    rdx(A_OUT, SZ_W, 32'h0000_31C3, "R5 16-bit check value, seed 0");

    // R3: seed load
    wr(A_CTRL, 4'h1, 32'h0);
    wr(A_SEED, 4'hF, 32'hDEAD_BEEF);
    rdx(A_OUT, SZ_W, 32'hDEAD_BEEF, "R3 seed visible next cycle");
    wr(A_CTRL, 4'h1, 32'h1);
    wr(A_SEED, 4'hF, 32'h1234_5678);
    rdx(A_OUT, SZ_W, 32'h0000_5678, "R3 16-bit seed low half only");
    rdx(A_SEED, SZ_W, 32'h0, "R11 seed reads zero");

    // R6: input order in both modes and sizes
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 2; o++) begin
        wr(A_CTRL, 4'h1, (o != 0 ? 32'h4 : 32'h0) | 32'(m));
        wr(A_SEED, 4'hF, 32'h0);
        wr(A_IN, 4'hF, 32'h1122_3344);
        rd(A_OUT, SZ_W, "R6 word input order");
        wr(A_IN, 4'b1100, 32'hAABB_0000);
        rd(A_OUT, SZ_W, "R6 upper half-word input order");
        wr(A_IN, 4'b0011, 32'h0000_5A3C);
        wr(A_IN, 4'b0100, 32'h00CC_0000);
        wr(A_IN, 4'b1000, 32'h9900_0000);
        rd(A_OUT, SZ_W, "R6 R12 back-to-back half and byte writes");
        wr(A_IN, 4'b0101, 32'h1234_5678);
        rd(A_OUT, SZ_W, "R4 illegal strobe ignored");
      end
    end
    wr(A_CTRL, 4'h1, 32'h4);
    wr(A_SEED, 4'hF, 32'h0);
    wr(A_IN, 4'hF, 32'h0000_0001);
    rdx(A_OUT, SZ_W, 32'h04C1_1DB7, "R6 high lane first puts lone 1 last");

    // R8 R9: output formatting
    wr(A_CTRL, 4'h1, 32'h10);
    wr(A_SEED, 4'hF, 32'h1122_3344);
    rdx(A_OUT, SZ_W, 32'h4433_2211, "R8 word swap");
    rdx(A_OUT, SZ_H, 32'h0000_4433, "R8 half swap");
    rdx(A_OUT, SZ_B, 32'h0000_0044, "R8 byte read");
    wr(A_CTRL, 4'h1, 32'h0);
    rdx(A_OUT, SZ_H, 32'h0000_3344, "R8 half without swap");
    wr(A_CTRL, 4'h1, 32'h11);
    wr(A_SEED, 4'hF, 32'h5555_ABCD);
    rdx(A_OUT, SZ_W, 32'h0000_CDAB, "R9 16-bit word swap");
    wr(A_CTRL, 4'h1, 32'h1);
    rdx(A_OUT, 2'd3, 32'h0000_ABCD, "R9 16-bit word, size code 3");

    // R7: result reflection
    wr(A_CTRL, 4'h1, 32'h2);
    wr(A_SEED, 4'hF, 32'h0000_0001);
    rdx(A_OUT, SZ_W, 32'h8000_0000, "R7 32-bit result reflect");
    wr(A_CTRL, 4'h1, 32'h3);
    wr(A_SEED, 4'hF, 32'h0000_0001);
    rdx(A_OUT, SZ_W, 32'h0000_8000, "R7 16-bit result reflect");
    wr(A_IN, 4'b0001, 32'h0000_0080);
    rd(A_OUT, SZ_W, "R7 reflected input byte");

    // R10 R11: alias window and reserved space
    wr(A_CTRL, 4'h1, 32'h0);
    wr(A_SEED, 4'hF, 32'h0);
    wr(13'h1800, 4'hF, 32'hCAFE_F00D);
    rd(A_OUT, SZ_W, "R10 first alias");
    wr(13'h1FFC, 4'hF, 32'h0BAD_BEEF);
    wr(13'h1A40, 4'b0011, 32'h0000_7E81);
    rd(A_OUT, SZ_W, "R10 last and middle alias");
    wr(13'h17FC, 4'hF, 32'h1111_1111);
    wr(13'h1110, 4'hF, 32'h2222_2222);
    wr(13'h0000, 4'hF, 32'h3333_3333);
    rd(A_OUT, SZ_W, "R11 reserved writes ignored");
    rd(A_CTRL, SZ_W, "R11 control untouched by reserved writes");
    rdx(13'h1110, SZ_W, 32'h0, "R11 reserved read zero");
    rdx(A_IN, SZ_W, 32'h0, "R11 input reads zero");
    rdx(13'h1804, SZ_W, 32'h0, "R11 alias reads zero");
    wr(A_IN, 4'hF, 32'h0000_0000);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; waddr = A_OUT[12:2];
    #(TCK/4);
    n_run++;
    if (rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R11 no read enable: got %08h expected 00000000", rdata);
    end
    rd(A_OUT, SZ_W, "R12 zero word folded");

    repeat (3) idle();
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule